// File: doc/BRIEF.md
# Touch Controller Serial Command Decoder

This block sits behind the byte shifter of a touchscreen controller's serial host port. It reads the incoming byte stream and sorts every byte into one of three slots. In the first slot, a byte with its top bit set is a command. A command either reloads the pending conversion setup (function, precision, sense enable) or resets the whole device. A nonzero first byte with its top bit clear opens a register transaction. The two bytes after it carry a 16-bit word, high byte first. A zero first byte is dropped, and the decoder stays in the first slot.

The block holds the configuration words and the four AUX and temperature limit words. For a read it takes a copy of the addressed word when the header arrives, then hands it to the shifter one byte per slot. Pen-down and conversion-busy status come in from the conversion engine and appear in the read image of configuration word 0. Raising chip select (`cs_n` high) always sends the decoder back to the first slot.

Top module: `touch_serial_decoder`

## Requirements
- R1: A first-slot byte with bit 7 set and bit 1 clear loads `pend_func` from bits 6:3 and `pend_prec` from bit 2, and sets `sense_en` to the inverse of bit 0. The new values are visible in the next cycle, and the next byte is again treated as a first byte.
- R2: A first-slot byte with bits 7 and 1 both set returns every owned register to its reset value: all configuration fields 0, sense disabled, pending function and precision 0, power-down select 0, AUX and temperature high limits 0x0FFF, low limits 0x0000. `dev_reset` is high for exactly one cycle, in the next cycle.
- R3: A first-slot byte of 0x00 changes no state, and the byte after it is decoded as a first byte.
- R4: A nonzero first byte with bit 7 clear is a header. Bits 6:3 give the address, bit 0 selects read (1) or write (0), and bit 1 appears on `pwrdn_sel` from the next cycle until the next header or device reset.
- R5: On a read, the word is captured as the header is accepted. `tx_byte` shows its bits 15:8 in the cycle after the header, its bits 7:0 in the cycle after the second byte, and 0 after the third byte.
- R6: On a write, the second byte gives bits 15:8 and the third gives bits 7:0. The target register changes in the cycle after the third byte. Writes to addresses other than 0x8 to 0xE leave all state unchanged.
- R7: A write to 0xC sets `host_mode` from bit 15, `sense_en` from the inverse of bit 14, `pend_prec` from bit 13 and `timing` from bits 12:0. `timing_bad` is high whenever `timing` bits 12:11 equal 3.
- R8: A write to 0xC with bit 14 set while `conv_busy` is high gives a one-cycle `conv_cancel` pulse in the cycle after the third byte.
- R9: A write to 0xD keeps only the bits under mask 0x0F07 and shows them on `cfg1`. A write to 0xE sets `pin_func` from bits 15:14 and `filter` from bits 13:0.
- R10: Address 0x8 is the AUX high limit, 0x9 the AUX low limit, 0xA the temperature high limit and 0xB the temperature low limit. Each stores and reads back the full 16-bit word.
- R11: Reading 0xC returns {`pen_down`, not `conv_busy`, `pend_prec`, `timing`} from bit 15 down. Reading 0xD returns `cfg1`, and reading 0xE returns {`pin_func`, `filter`}. Reading addresses outside 0x8 to 0xE returns 0.
- R12: While `cs_n` is high, `rx_valid` is ignored, `tx_byte` is 0 from the next cycle, and the next byte after `cs_n` falls is decoded as a first byte.
- R13: `tx_byte` is 0 during write transactions and after commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| pen_down | input | 1 | Pen-down status from sensing |
| conv_busy | input | 1 | Conversion engine busy |
| tx_byte | output | 8 | Byte for the shifter's next slot |
| pend_func | output | 4 | Pending conversion function |
| pend_prec | output | 1 | Pending precision |
| sense_en | output | 1 | Touch sensing enabled |
| host_mode | output | 1 | Host-controlled conversion mode |
| pwrdn_sel | output | 1 | Power-down select bit from the last header |
| timing | output | 13 | Timing field of configuration word 0 |
| timing_bad | output | 1 | Timing clock-select field holds the illegal value |
| cfg1 | output | 16 | Masked configuration word 1 |
| pin_func | output | 2 | Interrupt pin function |
| filter | output | 14 | Filter setting |
| dev_reset | output | 1 | One-cycle pulse after a reset command |
| conv_cancel | output | 1 | One-cycle pulse cancelling a conversion |

## Verification
Directed byte sequences cover each first-byte class: command, reset command, zero byte and read and write headers. Pairs of sequences separate neighbouring outcomes: a zero byte versus a header, a dropped address versus a stored one, and a write aborted by chip select versus a completed one. A mixed stream of random bytes with random chip-select drops is then compared every cycle against a behavioural model. This stream covers slot orderings the directed cases miss, such as a reset command arriving right after a partial write. Reads of configuration word 0 with `pen_down` and `conv_busy` set to different values show that the status bits come from the live inputs rather than stored state.

// File: rtl/tsd_pkg.sv
`timescale 1ns/1ps
package tsd_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int ADDR_W   = 4;
  localparam int FUNC_W   = 4;
  localparam int TIMING_W = 13;
  localparam int PIN_W    = 2;
  localparam int FILT_W   = WORD_W - PIN_W;
  localparam int N_LIMITS = 4;

  typedef enum logic [1:0] {SLOT_FIRST = 2'd0, SLOT_HI = 2'd1, SLOT_LO = 2'd2} slot_e;

  localparam logic [ADDR_W-1:0] A_LIMIT_BASE = 4'h8;
  localparam logic [ADDR_W-1:0] A_CFG0       = 4'hC;
  localparam logic [ADDR_W-1:0] A_CFG1       = 4'hD;
  localparam logic [ADDR_W-1:0] A_CFG2       = 4'hE;

  // read image of configuration word 0
  function automatic logic [WORD_W-1:0] cfg0_image(input logic pen, input logic busy,
                                                   input logic prec,
                                                   input logic [TIMING_W-1:0] tim);
    return {pen, ~busy, prec, tim};
  endfunction

  // clock-select field of the timing value must not be 3
  function automatic logic timing_illegal(input logic [TIMING_W-1:0] tim);
    return tim[TIMING_W-1 -: 2] == 2'b11;
  endfunction

  // limit words alternate high / low starting at the base address
  function automatic logic [WORD_W-1:0] limit_reset(input int idx, input logic [WORD_W-1:0] hi_v,
                                                    input logic [WORD_W-1:0] lo_v);
    return (idx % 2 == 0) ? hi_v : lo_v;
  endfunction
endpackage

// File: rtl/tsd_slot_ctrl.sv
`timescale 1ns/1ps
module tsd_slot_ctrl
  import tsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              cmd_evt,
  output logic              srst_evt,
  output logic              hdr_evt,
  output logic              mid_evt,
  output logic              last_evt,
  output logic              in_first,
  output logic              is_read,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              pwrdn_sel
);
  slot_e slot_q;
  logic  byte_evt;
  logic  first_evt;

  assign byte_evt  = rx_valid && !cs_n;
  assign in_first  = (slot_q == SLOT_FIRST);
  assign first_evt = byte_evt && in_first;

  always_comb begin
    cmd_evt  = first_evt && rx_byte[7] && !rx_byte[1];
    srst_evt = first_evt && rx_byte[7] && rx_byte[1];
    hdr_evt  = first_evt && !rx_byte[7] && (rx_byte != '0);
    mid_evt  = byte_evt && (slot_q == SLOT_HI);
    last_evt = byte_evt && (slot_q == SLOT_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q    <= SLOT_FIRST;
      reg_addr  <= '0;
      is_read   <= 1'b0;
      pwrdn_sel <= 1'b0;
    end else if (cs_n) begin
      slot_q <= SLOT_FIRST;
    end else begin
      if (hdr_evt) begin
        slot_q    <= SLOT_HI;
        reg_addr  <= rx_byte[6:3];
        is_read   <= rx_byte[0];
        pwrdn_sel <= rx_byte[1];
      end
      if (mid_evt)  slot_q    <= SLOT_LO;
      if (last_evt) slot_q    <= SLOT_FIRST;
      if (srst_evt) pwrdn_sel <= 1'b0;
    end
  end
endmodule

// File: rtl/tsd_regfile.sv
`timescale 1ns/1ps
module tsd_regfile
  import tsd_pkg::*;
#(
  parameter logic [WORD_W-1:0] LIMIT_HI_RST = 16'h0FFF,
  parameter logic [WORD_W-1:0] LIMIT_LO_RST = 16'h0000,
  parameter logic [WORD_W-1:0] CFG1_MASK    = 16'h0F07
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_evt,
  input  logic                srst_evt,
  input  logic                mid_evt,
  input  logic                last_evt,
  input  logic                is_read,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                pen_down,
  input  logic                conv_busy,
  output logic [WORD_W-1:0]   rd_word,
  output logic [FUNC_W-1:0]   pend_func,
  output logic                pend_prec,
  output logic                sense_en,
  output logic                host_mode,
  output logic [TIMING_W-1:0] timing,
  output logic [WORD_W-1:0]   cfg1,
  output logic [PIN_W-1:0]    pin_func,
  output logic [FILT_W-1:0]   filter,
  output logic                dev_reset,
  output logic                conv_cancel
);
  logic [N_LIMITS-1:0][WORD_W-1:0] limit_q;
  logic [BYTE_W-1:0]               wr_hi_q;
  logic [WORD_W-1:0]               wr_word;
  logic                            wr_en;
  logic [ADDR_W-1:0]               rd_addr;

  assign wr_word = {wr_hi_q, rx_byte};
  assign wr_en   = last_evt && !is_read;
  assign rd_addr = rx_byte[6:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_LIMITS; i++)
        limit_q[i] <= limit_reset(i, LIMIT_HI_RST, LIMIT_LO_RST);
    end else begin
      for (int i = 0; i < N_LIMITS; i++) begin
        if (srst_evt)
          limit_q[i] <= limit_reset(i, LIMIT_HI_RST, LIMIT_LO_RST);
        else if (wr_en && reg_addr == A_LIMIT_BASE + ADDR_W'(i))
          limit_q[i] <= wr_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_func   <= '0;
      pend_prec   <= 1'b0;
      sense_en    <= 1'b0;
      host_mode   <= 1'b0;
      timing      <= '0;
      cfg1        <= '0;
      pin_func    <= '0;
      filter      <= '0;
      wr_hi_q     <= '0;
      dev_reset   <= 1'b0;
      conv_cancel <= 1'b0;
    end else begin
      dev_reset   <= srst_evt;
      conv_cancel <= 1'b0;
      if (srst_evt) begin
        pend_func <= '0;
        pend_prec <= 1'b0;
        sense_en  <= 1'b0;
        host_mode <= 1'b0;
        timing    <= '0;
        cfg1      <= '0;
        pin_func  <= '0;
        filter    <= '0;
        wr_hi_q   <= '0;
      end else begin
        if (cmd_evt) begin
          pend_func <= rx_byte[6:3];
          pend_prec <= rx_byte[2];
          sense_en  <= !rx_byte[0];
        end
        if (mid_evt && !is_read) wr_hi_q <= rx_byte;
        if (wr_en) begin
          case (reg_addr)
            A_CFG0: begin
              host_mode   <= wr_word[15];
              sense_en    <= !wr_word[14];
              pend_prec   <= wr_word[13];
              timing      <= wr_word[TIMING_W-1:0];
              conv_cancel <= wr_word[14] && conv_busy;
            end
            A_CFG1: cfg1 <= wr_word & CFG1_MASK;
            A_CFG2: begin
              pin_func <= wr_word[WORD_W-1 -: PIN_W];
              filter   <= wr_word[FILT_W-1:0];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_CFG0:  rd_word = cfg0_image(pen_down, conv_busy, pend_prec, timing);
      A_CFG1:  rd_word = cfg1;
      A_CFG2:  rd_word = {pin_func, filter};
      default: rd_word = (rd_addr[3:2] == A_LIMIT_BASE[3:2]) ? limit_q[rd_addr[1:0]] : '0;
    endcase
  end
endmodule

// File: rtl/tsd_tx_path.sv
`timescale 1ns/1ps
module tsd_tx_path
  import tsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic              hdr_evt,
  input  logic              hdr_read,
  input  logic              mid_evt,
  input  logic              is_read,
  input  logic [WORD_W-1:0] rd_word,
  output logic [BYTE_W-1:0] tx_byte
);
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      lo_q    <= '0;
    end else if (cs_n) begin
      tx_byte <= '0;
    end else if (hdr_evt && hdr_read) begin
      tx_byte <= rd_word[WORD_W-1 -: BYTE_W];
      lo_q    <= rd_word[BYTE_W-1:0];
    end else if (mid_evt && is_read) begin
      tx_byte <= lo_q;
    end else if (rx_valid) begin
      tx_byte <= '0;
    end
  end
endmodule

// File: rtl/touch_serial_decoder.sv
`timescale 1ns/1ps
module touch_serial_decoder
  import tsd_pkg::*;
#(
  parameter logic [15:0] LIMIT_HI_RST = 16'h0FFF,
  parameter logic [15:0] LIMIT_LO_RST = 16'h0000,
  parameter logic [15:0] CFG1_MASK    = 16'h0F07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        pen_down,
  input  logic        conv_busy,
  output logic [7:0]  tx_byte,
  output logic [3:0]  pend_func,
  output logic        pend_prec,
  output logic        sense_en,
  output logic        host_mode,
  output logic        pwrdn_sel,
  output logic [12:0] timing,
  output logic        timing_bad,
  output logic [15:0] cfg1,
  output logic [1:0]  pin_func,
  output logic [13:0] filter,
  output logic        dev_reset,
  output logic        conv_cancel
);
  logic              cmd_evt, srst_evt, hdr_evt, mid_evt, last_evt;
  logic              in_first, is_read;
  logic [ADDR_W-1:0] reg_addr;
  logic [WORD_W-1:0] rd_word;

  tsd_slot_ctrl u_slot (
    .clk, .rst_n, .cs_n, .rx_valid, .rx_byte,
    .cmd_evt, .srst_evt, .hdr_evt, .mid_evt, .last_evt,
    .in_first, .is_read, .reg_addr, .pwrdn_sel
  );

  tsd_regfile #(
    .LIMIT_HI_RST(LIMIT_HI_RST), .LIMIT_LO_RST(LIMIT_LO_RST), .CFG1_MASK(CFG1_MASK)
  ) u_regs (
    .clk, .rst_n, .cmd_evt, .srst_evt, .mid_evt, .last_evt, .is_read, .reg_addr,
    .rx_byte, .pen_down, .conv_busy, .rd_word,
    .pend_func, .pend_prec, .sense_en, .host_mode, .timing, .cfg1,
    .pin_func, .filter, .dev_reset, .conv_cancel
  );

  tsd_tx_path u_tx (
    .clk, .rst_n, .cs_n, .rx_valid,
    .hdr_evt, .hdr_read(rx_byte[0]), .mid_evt, .is_read, .rd_word, .tx_byte
  );

  assign timing_bad = timing_illegal(timing);
endmodule

// File: rtl/tsd_checker.sv
`timescale 1ns/1ps
module tsd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic [7:0]  rx_byte,
  input logic        rx_valid,
  input logic [7:0]  tx_byte,
  input logic [3:0]  pend_func,
  input logic        pend_prec,
  input logic        sense_en,
  input logic [12:0] timing,
  input logic [15:0] cfg1,
  input logic        dev_reset,
  input logic        conv_cancel,
  input logic        cmd_evt,
  input logic        srst_evt,
  input logic        hdr_evt,
  input logic        mid_evt,
  input logic        last_evt,
  input logic        in_first
);
  p_cmd_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_evt |=> (pend_func == $past(rx_byte[6:3]) && pend_prec == $past(rx_byte[2])
                 && sense_en == !$past(rx_byte[0])));
  p_cmd_stays_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_evt |=> in_first);
  p_soft_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    srst_evt |=> (dev_reset && timing == '0 && !sense_en && cfg1 == '0));
  p_zero_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cs_n && in_first && rx_byte == 8'h00) |=> in_first);
  p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_evt, srst_evt, hdr_evt, mid_evt, last_evt}));
  p_cancel_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_cancel |-> !sense_en);
  p_cfg1_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg1 & ~16'h0F07) == 16'h0000);
  p_cs_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (tx_byte == 8'h00 && in_first));
  p_last_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> tx_byte == 8'h00);
endmodule

bind touch_serial_decoder tsd_checker u_tsd_checker (.*);

// File: tb/test_touch_serial_decoder.sv
`timescale 1ns/1ps
module test_touch_serial_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b0, rx_valid = 1'b0, pen_down = 1'b0, conv_busy = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [7:0]  tx_byte;
  logic [3:0]  pend_func;
  logic        pend_prec, sense_en, host_mode, pwrdn_sel, timing_bad, dev_reset, conv_cancel;
  logic [12:0] timing;
  logic [15:0] cfg1;
  logic [1:0]  pin_func;
  logic [13:0] filter;

  touch_serial_decoder i_touch_serial_decoder (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_slot;
  logic [3:0] m_addr;
  bit         m_rd, m_pds, m_prec, m_sense, m_host, m_drst, m_cancel;
  logic [7:0] m_hi, m_tx, m_lo;
  logic [15:0] m_lim[4];
  logic [3:0] m_func;
  logic [12:0] m_tim;
  logic [15:0] m_cfg1;
  logic [1:0] m_pin;
  logic [13:0] m_filt;

  task automatic m_clear();
    m_pds = 0; m_prec = 0; m_sense = 0; m_host = 0; m_func = 0; m_tim = 0;
    m_cfg1 = 0; m_pin = 0; m_filt = 0; m_hi = 0;
    m_lim[0] = 16'h0FFF; m_lim[1] = 16'h0000; m_lim[2] = 16'h0FFF; m_lim[3] = 16'h0000;
  endtask

  function automatic logic [15:0] m_read(input logic [3:0] a);
    if (a >= 4'h8 && a <= 4'hB) return m_lim[a - 4'h8];
    if (a == 4'hC) return (16'(pen_down) << 15) | (16'(!conv_busy) << 14) | (16'(m_prec) << 13) | 16'(m_tim);
    if (a == 4'hD) return m_cfg1;
    if (a == 4'hE) return (16'(m_pin) << 14) | 16'(m_filt);
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    logic [15:0] w;
    m_drst = 0; m_cancel = 0;
    if (!rst_n) begin
      m_clear(); m_slot = 0; m_addr = 0; m_rd = 0; m_tx = 0; m_lo = 0;
    end else if (cs_n) begin
      m_slot = 0; m_tx = 0;
    end else if (rx_valid) begin
      m_tx = 0;
      if (m_slot == 0) begin
        if (rx_byte[7]) begin
          if (rx_byte[1]) begin m_clear(); m_drst = 1; end
          else begin m_func = rx_byte[6:3]; m_prec = rx_byte[2]; m_sense = !rx_byte[0]; end
        end else if (rx_byte != 0) begin
          m_addr = rx_byte[6:3]; m_rd = rx_byte[0]; m_pds = rx_byte[1]; m_slot = 1;
          if (m_rd) begin w = m_read(m_addr); m_tx = w[15:8]; m_lo = w[7:0]; end
        end
      end else if (m_slot == 1) begin
        if (m_rd) m_tx = m_lo; else m_hi = rx_byte;
        m_slot = 2;
      end else begin
        m_slot = 0;
        if (!m_rd) begin
          w = {m_hi, rx_byte};
          case (m_addr)
            4'h8, 4'h9, 4'hA, 4'hB: m_lim[m_addr - 4'h8] = w;
            4'hC: begin
              m_host = w[15]; m_sense = !w[14]; m_prec = w[13]; m_tim = w[12:0];
              m_cancel = w[14] && conv_busy;
            end
            4'hD: m_cfg1 = w & 16'h0F07;
            4'hE: begin m_pin = w[15:14]; m_filt = w[13:0]; end
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 model tx_byte", 32'(tx_byte), 32'(m_tx));
      chk("R1 model pend_func", 32'(pend_func), 32'(m_func));
      chk("R7 model pend_prec", 32'(pend_prec), 32'(m_prec));
      chk("R1 model sense_en", 32'(sense_en), 32'(m_sense));
      chk("R7 model host_mode", 32'(host_mode), 32'(m_host));
      chk("R7 model timing", 32'(timing), 32'(m_tim));
      chk("R7 model timing_bad", 32'(timing_bad), 32'(m_tim[12:11] == 2'b11));
      chk("R9 model cfg1", 32'(cfg1), 32'(m_cfg1));
      chk("R9 model pin/filter", {16'h0, pin_func, filter}, {16'h0, m_pin, m_filt});
      chk("R4 model pwrdn_sel", 32'(pwrdn_sel), 32'(m_pds));
      chk("R2 model dev_reset", 32'(dev_reset), 32'(m_drst));
      chk("R8 model conv_cancel", 32'(conv_cancel), 32'(m_cancel));
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_byte = 8'h00;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset tx_byte", 32'(tx_byte), 0);
    chk("R2 reset sense_en", 32'(sense_en), 0);
    chk("R2 reset cfg1", 32'(cfg1), 0);

    // R10 / R5: read AUX high limit (reset 0x0FFF)
    send(8'h41); chk("R5 R10 aux hi byte", 32'(tx_byte), 32'h0F);
    send(8'h00); chk("R5 R10 aux lo byte", 32'(tx_byte), 32'hFF);
    send(8'h00); chk("R5 after third byte", 32'(tx_byte), 0);
    send(8'h49); chk("R10 aux low limit hi", 32'(tx_byte), 0);
    send(8'h00); send(8'h00);

    // R1 command
    send(8'hAC);
    chk("R1 pend_func", 32'(pend_func), 5);
    chk("R1 pend_prec", 32'(pend_prec), 1);
    chk("R1 sense_en", 32'(sense_en), 1);
    chk("R13 tx after command", 32'(tx_byte), 0);
    // R3 zero byte ignored
    send(8'h00); chk("R3 zero keeps func", 32'(pend_func), 5);
    send(8'h81);
    chk("R3 next byte is command", 32'(pend_func), 0);
    chk("R1 sense off", 32'(sense_en), 0);

    // R9 cfg1 mask
    send(8'h68); send(8'hFF); chk("R13 tx during write", 32'(tx_byte), 0);
    send(8'hFF); chk("R9 cfg1 masked", 32'(cfg1), 32'h0F07);
    send(8'h70); send(8'hC1); send(8'h23);
    chk("R9 pin_func", 32'(pin_func), 3);
    chk("R9 filter", 32'(filter), 32'h0123);

    // R7 cfg0 write
    send(8'h60); send(8'hB8); send(8'h05);
    chk("R7 host_mode", 32'(host_mode), 1);
    chk("R7 sense_en", 32'(sense_en), 1);
    chk("R7 pend_prec", 32'(pend_prec), 1);
    chk("R7 timing", 32'(timing), 32'h1805);
    chk("R7 timing_bad", 32'(timing_bad), 1);

    // R11 cfg0 read image
    pen_down = 1'b1; conv_busy = 1'b0;
    send(8'h61); chk("R11 cfg0 hi", 32'(tx_byte), 32'hF8);
    send(8'h00); chk("R11 cfg0 lo", 32'(tx_byte), 32'h05);
    send(8'h00);
    send(8'h11); chk("R11 unowned read hi", 32'(tx_byte), 0);
    send(8'h00); chk("R11 unowned read lo", 32'(tx_byte), 0);
    send(8'h00);

    // R8 cancel
    conv_busy = 1'b1;
    send(8'h60); send(8'h40); send(8'h00);
    chk("R8 conv_cancel pulse", 32'(conv_cancel), 1);
    chk("R8 sense disabled", 32'(sense_en), 0);
    @(negedge clk);
    chk("R8 pulse one cycle", 32'(conv_cancel), 0);
    conv_busy = 1'b0; pen_down = 1'b0;

    // R6 write to unowned address
    send(8'h18); send(8'hAB); send(8'hCD);
    chk("R6 ignored keeps cfg1", 32'(cfg1), 32'h0F07);
    chk("R6 ignored keeps filter", 32'(filter), 32'h0123);
    send(8'h59); chk("R6 temp low untouched", 32'(tx_byte), 0);
    send(8'h00); send(8'h00);
    // R6 / R10 write then read temp low limit
    send(8'h58); send(8'h12); send(8'h34);
    send(8'h59); chk("R10 temp low hi", 32'(tx_byte), 32'h12);
    send(8'h00); chk("R6 temp low lo", 32'(tx_byte), 32'h34);
    send(8'h00);

    // R4 power-down select
    send(8'h4B); chk("R4 pwrdn_sel set", 32'(pwrdn_sel), 1);
    send(8'h00); send(8'h00);
    send(8'h49); chk("R4 pwrdn_sel clear", 32'(pwrdn_sel), 0);
    send(8'h00); send(8'h00);

    // R12 chip select abort
    send(8'h50); send(8'h77);
    cs_n = 1'b1; rx_valid = 1'b1; rx_byte = 8'h82;
    @(negedge clk);
    chk("R12 tx cleared", 32'(tx_byte), 0);
    chk("R12 byte ignored", 32'(dev_reset), 0);
    cs_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    send(8'hAD); chk("R12 first slot after cs", 32'(pend_func), 5);
    send(8'h51); chk("R12 no write hi", 32'(tx_byte), 32'h0F);
    send(8'h00); chk("R12 no write lo", 32'(tx_byte), 32'hFF);
    send(8'h00);

    // R2 soft reset
    send(8'h82);
    chk("R2 dev_reset pulse", 32'(dev_reset), 1);
    chk("R2 cfg1 cleared", 32'(cfg1), 0);
    chk("R2 pin_func cleared", 32'(pin_func), 0);
    chk("R2 func cleared", 32'(pend_func), 0);
    @(negedge clk);
    chk("R2 pulse one cycle", 32'(dev_reset), 0);
    send(8'h59); chk("R2 temp low reset", 32'(tx_byte), 0);
    send(8'h00); chk("R2 temp low reset lo", 32'(tx_byte), 0);
    send(8'h00);

    // mixed stream compared against the model
    for (int i = 0; i < 3000; i++) begin
      pen_down  = 1'($urandom);
      conv_busy = 1'($urandom);
      cs_n      = ($urandom % 16) == 0;
      rx_valid  = ($urandom % 3) != 0;
      rx_byte   = 8'($urandom);
      @(negedge clk);
    end
    rx_valid = 1'b0; cs_n = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule